// File: doc/BRIEF.md
# Lane-Partitioned Packed Integer Adder

This block adds or subtracts two 256-bit operands that hold packed integers. A three-bit width select tells it how the operands are cut into lanes of equal size: 8, 16, 32 or 64 bits, or one lane covering all 256 bits. The carry chain is broken at every lane edge. One adder therefore serves every packed integer type, and each lane gets the same result a separate adder of that width would give. Every lane computes on every operation; there is no per-lane enable and no element count. The number of lanes follows from the width select alone.

The datapath is built from 8-bit slices. The carry into a slice comes from the slice below it, unless that slice starts a lane in the selected mode. In that case the carry in is a constant: 0 for addition, 1 for subtraction (two's complement of the second operand). A saturating mode can be selected. It clamps each lane on its own to the unsigned or signed range when that lane overflows. The result and a valid flag are registered, so the result appears one clock after the input valid.

Top module: `psimd_adder`

## Requirements
- R1: The width select `lane_sel` picks the lane size: 0 gives 8 bits, 1 gives 16, 2 gives 32, 3 gives 64, 4 gives one 256-bit lane, and 5 to 7 act as 8 bits. No carry or borrow crosses from one lane into the next.
- R2: With `sub_en`=0 and `sat_en`=0, each lane of `sum` equals the lane of `op_a` plus the lane of `op_b`, modulo 2^width.
- R3: With `sub_en`=1 and `sat_en`=0, each lane equals the `op_a` lane minus the `op_b` lane, modulo 2^width.
- R4: With `sat_en`=1, `sat_signed`=0 and `sub_en`=0, a lane whose unsigned sum exceeds 2^width-1 reads all ones. Every other lane reads its exact sum.
- R5: With `sat_en`=1, `sat_signed`=0 and `sub_en`=1, a lane where `op_b` is greater than `op_a` (unsigned) reads zero. Every other lane reads its exact difference.
- R6: With `sat_en`=1 and `sat_signed`=1, a lane whose signed result exceeds 2^(width-1)-1 reads that maximum, and one below -2^(width-1) reads that minimum. This applies to addition and to subtraction, and each lane is clamped on its own.
- R7: When `sat_en`=0, `sat_signed` has no effect on `sum`.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `sum` carries that operation's result in the same cycle.
- R9: A cycle with `in_valid` low leaves `sum` unchanged.
- R10: While reset is asserted, `out_valid` is 0 and `sum` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| lane_sel | input | 3 | Lane width select (see R1) |
| sub_en | input | 1 | 1: op_a minus op_b; 0: op_a plus op_b |
| sat_en | input | 1 | 1: saturate each lane on overflow |
| sat_signed | input | 1 | Saturation range: 1 signed, 0 unsigned |
| op_a | input | 256 | First packed operand |
| op_b | input | 256 | Second packed operand |
| out_valid | output | 1 | Registered result valid |
| sum | output | 256 | Registered packed result |

## Verification
Two functions can act in the same lane in the same cycle. The first is a carry rippling between the 8-bit slices inside a wide lane. The second is the overflow clamp, which takes its decision from the top slice of that lane and must rewrite every slice of it. Directed vectors provoke both at once, for example signed 16-bit lanes holding 0x7FFF plus 1 and unsigned 256-bit all ones plus 1. Random vectors across every mode repeat the case many times. Each result is compared, lane by lane, with a bench model that computes each lane at full precision and clamps it.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

  // Lane width codes carried on lane_sel
  typedef enum logic [2:0] {
    LW_8   = 3'd0,
    LW_16  = 3'd1,
    LW_32  = 3'd2,
    LW_64  = 3'd3,
    LW_ALL = 3'd4
  } lane_w_e;

  // Per-slice flags gathered from the adder, used by the clamp stage
  typedef struct packed {
    logic cout;   // carry out of slice MSB
    logic cmsb;   // carry into slice MSB
    logic a_msb;  // MSB of operand A in this slice
  } slice_flags_t;

endpackage

// File: rtl/psimd_lane_map.sv
module psimd_lane_map #(
  parameter int unsigned NSLICE = 32,
  localparam int unsigned IDX_W = $clog2(NSLICE)
) (
  input  logic [2:0]        lane_sel,
  output logic [IDX_W-1:0]  lane_mask,
  output logic [NSLICE-1:0] slice_first
);
  import psimd_pkg::*;

  // lane_mask = (slices per lane) - 1
  always_comb begin
    unique case (lane_w_e'(lane_sel))
      LW_16:   lane_mask = IDX_W'(1);
      LW_32:   lane_mask = IDX_W'(3);
      LW_64:   lane_mask = IDX_W'(7);
      LW_ALL:  lane_mask = {IDX_W{1'b1}};
      default: lane_mask = '0;
    endcase
  end

  for (genvar i = 0; i < NSLICE; i++) begin : g_first
    assign slice_first[i] = ((IDX_W'(i) & lane_mask) == '0);
  end

endmodule

// File: rtl/psimd_slice_add.sv
module psimd_slice_add #(
  parameter int unsigned SW = 8
) (
  input  logic          cin,
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  output logic [SW-1:0] s,
  output logic          cout,
  output logic          cmsb
);
  logic [SW-1:0] low;

  // lower bits, carry into MSB kept separate for signed overflow
  assign low  = {1'b0, a[SW-2:0]} + {1'b0, b[SW-2:0]} + {{(SW-1){1'b0}}, cin};
  assign cmsb = low[SW-1];
  assign {cout, s[SW-1]} = {1'b0, a[SW-1]} + {1'b0, b[SW-1]} + {1'b0, cmsb};
  assign s[SW-2:0] = low[SW-2:0];

endmodule

// File: rtl/psimd_clamp.sv
module psimd_clamp #(
  parameter int unsigned SW = 8
) (
  input  logic                     sat_en,
  input  logic                     sat_signed,
  input  logic                     sub_en,
  input  logic                     is_top,
  input  psimd_pkg::slice_flags_t  top_flags,
  input  logic [SW-1:0]            raw,
  output logic [SW-1:0]            res
);
  logic hit_u, hit_s;
  logic [SW-1:0] val_u, val_s;

  // unsigned: add overflows on carry out, subtract underflows on no carry out
  assign hit_u = sub_en ? ~top_flags.cout : top_flags.cout;
  assign val_u = sub_en ? {SW{1'b0}} : {SW{1'b1}};

  // signed: carries into and out of lane MSB disagree
  assign hit_s = top_flags.cmsb ^ top_flags.cout;
  always_comb begin
    if (top_flags.a_msb) val_s = is_top ? {1'b1, {(SW-1){1'b0}}} : {SW{1'b0}};
    else                 val_s = is_top ? {1'b0, {(SW-1){1'b1}}} : {SW{1'b1}};
  end

  always_comb begin
    res = raw;
    if (sat_en) begin
      if (sat_signed) begin
        if (hit_s) res = val_s;
      end else if (hit_u) begin
        res = val_u;
      end
    end
  end

endmodule

// File: rtl/psimd_adder.sv
module psimd_adder #(
  parameter int unsigned DATA_W  = 256,
  parameter int unsigned SLICE_W = 8,
  localparam int unsigned NSLICE = DATA_W / SLICE_W,
  localparam int unsigned IDX_W  = $clog2(NSLICE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        lane_sel,
  input  logic              sub_en,
  input  logic              sat_en,
  input  logic              sat_signed,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] sum
);
  import psimd_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // lane boundaries
  logic [IDX_W-1:0]  lane_mask;
  logic [NSLICE-1:0] slice_first;

  psimd_lane_map #(.NSLICE(NSLICE)) u_map (
    .lane_sel    (lane_sel),
    .lane_mask   (lane_mask),
    .slice_first (slice_first)
  );

  // slice adders with carry cut at lane starts
  logic [DATA_W-1:0]  b_eff;
  logic [DATA_W-1:0]  raw_sum;
  logic [NSLICE-1:0]  cin, cout, cmsb;
  slice_flags_t       flags [NSLICE];

  assign b_eff = sub_en ? ~op_b : op_b;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    if (i == 0) begin : g_c0
      assign cin[i] = sub_en;
    end else begin : g_cn
      assign cin[i] = slice_first[i] ? sub_en : cout[i-1];
    end

    psimd_slice_add #(.SW(SLICE_W)) u_add (
      .cin  (cin[i]),
      .a    (op_a[i*SLICE_W +: SLICE_W]),
      .b    (b_eff[i*SLICE_W +: SLICE_W]),
      .s    (raw_sum[i*SLICE_W +: SLICE_W]),
      .cout (cout[i]),
      .cmsb (cmsb[i])
    );

    assign flags[i] = '{cout: cout[i], cmsb: cmsb[i], a_msb: op_a[i*SLICE_W + SLICE_W - 1]};
  end

  // per-slice clamp driven by its lane's top slice
  logic [DATA_W-1:0] res_d;

  for (genvar i = 0; i < NSLICE; i++) begin : g_sat
    logic [IDX_W-1:0] top_idx;
    slice_flags_t     top_f;

    assign top_idx = IDX_W'(i) | lane_mask;
    assign top_f   = flags[top_idx];

    psimd_clamp #(.SW(SLICE_W)) u_clamp (
      .sat_en     (sat_en),
      .sat_signed (sat_signed),
      .sub_en     (sub_en),
      .is_top     (top_idx == IDX_W'(i)),
      .top_flags  (top_f),
      .raw        (raw_sum[i*SLICE_W +: SLICE_W]),
      .res        (res_d[i*SLICE_W +: SLICE_W])
    );
  end

  // next state
  logic              valid_d;
  logic              sum_en;
  logic [DATA_W-1:0] sum_d;

  always_comb begin
    valid_d = in_valid;
    sum_en  = in_valid;
    sum_d   = res_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
    end else begin
      out_valid <= valid_d;
      if (sum_en) sum <= sum_d;
    end
  end

endmodule

// File: rtl/psimd_adder_chk.sv
module psimd_adder_chk #(
  parameter int unsigned DATA_W = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        lane_sel,
  input logic              sub_en,
  input logic              sat_en,
  input logic              sat_signed,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] sum
);

  // R8
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  a_r9_hold_sum: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sum));

  // R2: the lowest byte is a plain modular sum in every lane width
  a_r2_low_byte_add: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sub_en && !sat_en) |=> (sum[7:0] == $past(op_a[7:0] + op_b[7:0])));

  // R3
  a_r3_low_byte_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_en && !sat_en) |=> (sum[7:0] == $past(op_a[7:0] - op_b[7:0])));

  // R4: unsigned saturating add never drops below op_a in a byte lane
  a_r4_usat_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && !sat_signed && !sub_en && lane_sel == 3'd0)
      |=> (sum[7:0] >= $past(op_a[7:0])));

  // R5: unsigned saturating subtract never rises above op_a in a byte lane
  a_r5_usat_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_en && !sat_signed && sub_en && lane_sel == 3'd0)
      |=> (sum[7:0] <= $past(op_a[7:0])));

  // R10
  always @(posedge clk) begin
    if (!rst_n) a_r10_reset_idle: assert (!out_valid && sum == '0);
  end

endmodule

bind psimd_adder psimd_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .lane_sel   (lane_sel),
  .sub_en     (sub_en),
  .sat_en     (sat_en),
  .sat_signed (sat_signed),
  .op_a       (op_a),
  .op_b       (op_b),
  .out_valid  (out_valid),
  .sum        (sum)
);

// File: tb/tb_psimd_adder.sv
module tb_psimd_adder;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   lane_sel;
  logic         sub_en, sat_en, sat_signed;
  logic [255:0] op_a, op_b;
  logic         out_valid;
  logic [255:0] sum;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  psimd_adder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_sel(lane_sel),
    .sub_en(sub_en), .sat_en(sat_en), .sat_signed(sat_signed),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .sum(sum)
  );

  function automatic int lane_w(logic [2:0] sel);
    case (sel)
      3'd1: return 16;
      3'd2: return 32;
      3'd3: return 64;
      3'd4: return 256;
      default: return 8;
    endcase
  endfunction

  // lane-by-lane model at full precision
  function automatic logic [255:0] model(logic [255:0] a, logic [255:0] b,
      logic [2:0] sel, logic sub, logic sat, logic sgn);
    int w = lane_w(sel);
    logic [255:0] r = '0;
    for (int l = 0; l < 256 / w; l++) begin
      logic [257:0] m, ua, ub, ur, lane;
      logic signed [259:0] pw, sa, sb, sr, smax, smin;
      m  = (258'(1) << w) - 258'(1);
      ua = 258'(a >> (l * w)) & m;
      ub = 258'(b >> (l * w)) & m;
      ur = sub ? ua - ub : ua + ub;
      lane = ur & m;
      if (sat && !sgn) begin
        if (!sub && ur[w]) lane = m;
        if (sub && ua < ub) lane = '0;
      end
      if (sat && sgn) begin
        pw = 260'sd1 <<< w;
        sa = $signed(260'(ua)) - (ua[w-1] ? pw : 260'sd0);
        sb = $signed(260'(ub)) - (ub[w-1] ? pw : 260'sd0);
        sr = sub ? sa - sb : sa + sb;
        smax = (pw >>> 1) - 260'sd1;
        smin = -(pw >>> 1);
        if (sr > smax) lane = 258'(smax) & m;
        if (sr < smin) lane = 258'(smin) & m;
      end
      r = r | (256'(lane) << (l * w));
    end
    return r;
  endfunction

  function automatic string tag_of(logic sub, logic sat, logic sgn);
    if (sat) return sgn ? "R6" : (sub ? "R5" : "R4");
    return sub ? "R3" : "R2";
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at next negedge
  task automatic apply(logic [255:0] a, logic [255:0] b, logic [2:0] sel,
      logic sub, logic sat, logic sgn, string req);
    logic [255:0] exp;
    in_valid = 1'b1; op_a = a; op_b = b; lane_sel = sel;
    sub_en = sub; sat_en = sat; sat_signed = sgn;
    exp = model(a, b, sel, sub, sat, sgn);
    @(negedge clk);
    check(out_valid === 1'b1, "R8", 256'(out_valid), 256'(1));
    check(sum === exp, req, sum, exp);
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; in_valid = 1'b0; lane_sel = 3'd0;
    sub_en = 1'b0; sat_en = 1'b0; sat_signed = 1'b0;
    op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10", 256'(out_valid), 256'(0));
    check(sum === '0, "R10", sum, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: all ones plus one in each width; carry must stop at every lane edge
    for (int s = 0; s < 8; s++)
      apply({256{1'b1}}, 256'(1) | (256'(1) << 64) | (256'(1) << 128),
            3'(s), 1'b0, 1'b0, 1'b0, "R1");
    // R1: borrow must not cross lanes
    for (int s = 0; s < 5; s++)
      apply('0, {32{8'h01}}, 3'(s), 1'b1, 1'b0, 1'b0, "R1");

    // R6: signed 16-bit lanes with carry between slices and clamp together
    apply({16{16'h7FFF}}, {16{16'h0001}}, 3'd1, 1'b0, 1'b1, 1'b1, "R6");
    apply({16{16'h8000}}, {16{16'h0001}}, 3'd1, 1'b1, 1'b1, 1'b1, "R6");
    // R4: unsigned whole-width overflow
    apply({256{1'b1}}, 256'(1), 3'd4, 1'b0, 1'b1, 1'b0, "R4");
    // R5: unsigned byte underflow
    apply('0, {32{8'h01}}, 3'd0, 1'b1, 1'b1, 1'b0, "R5");
    // R7: sat_signed without sat_en gives the wrapped result
    apply({16{16'h7FFF}}, {16{16'h0001}}, 3'd1, 1'b0, 1'b0, 1'b1, "R7");
    apply('0, {32{8'h01}}, 3'd2, 1'b1, 1'b0, 1'b1, "R7");

    // R9: idle cycle with new operands must not change sum
    begin
      logic [255:0] held;
      held = sum;
      in_valid = 1'b0; op_a = rnd256(); op_b = rnd256();
      @(negedge clk);
      check(out_valid === 1'b0, "R8", 256'(out_valid), 256'(0));
      check(sum === held, "R9", sum, held);
    end

    // random mix over all modes
    for (int n = 0; n < 600; n++) begin
      logic [2:0] sel;
      logic sb, st, sg;
      sel = 3'($urandom_range(0, 7));
      sb = 1'($urandom); st = 1'($urandom); sg = 1'($urandom);
      apply(rnd256(), rnd256(), sel, sb, st, sg, tag_of(sb, st, sg));
      if ($urandom_range(0, 7) == 0) begin
        logic [255:0] held;
        held = sum;
        in_valid = 1'b0; op_a = rnd256();
        @(negedge clk);
        check(sum === held, "R9", sum, held);
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule